// File: doc/BRIEF.md
# Serial Host-Write Frame Receiver

This block is the receive half of a slave serial port through which an external controller loads bytes into a bridge. The controller drives three wires, all asynchronous to the bridge clock: a frame line, a serial clock and a data line. Each wire goes through a synchronizer and a persistence filter that rejects short glitches. The block then samples the data line on every rising edge of the filtered serial clock.

Every frame opens with a one-byte header. The header names the target, carries a toggle flag and gives the byte count to be offered on the USB side. When the target is the endpoint transmit FIFO, the payload bytes are pushed into an internal byte FIFO. When the target is a register, the payload bytes are issued as synchronous register writes. At the close of a FIFO frame, the header count and toggle are latched for the USB side and the endpoint's "transmit done" flag is cleared, which re-arms the endpoint. The USB side drains the FIFO through a pop port and reports each completed transmission on a strobe.

Top module: `ser_load_rx`

## Requirements
- R1: After reset, `fifo_fill` is 0, `ep_done` is 1, `ep_count` is 0, `ep_toggle` is 0 and `reg_wr` is 0.
- R2: A frame opens on a rising edge of `sin`. Bits are sampled from `sdi` on rising `sck` edges, least significant bit first, in groups of 8. The first group is the header; each later group is one payload byte.
- R3: Each payload byte of a FIFO frame raises `fifo_fill` by one. When the FIFO already holds `FIFO_DEPTH` bytes, a new byte overwrites the oldest one and `fifo_fill` stays at `FIFO_DEPTH`.
- R4: The header layout is: bits 7:5 target, bit 4 toggle, bits 3:0 count. Target 0 selects the transmit FIFO. When a FIFO frame closes (falling `sin` after a complete header), `ep_count` takes the header count, `ep_toggle` takes the header toggle and `ep_done` drops to 0.
- R5: For a nonzero target, each payload byte gives a one-cycle `reg_wr` pulse, with `reg_addr` equal to the target and `reg_wdata` equal to the byte. In that case the FIFO, `ep_count`, `ep_toggle` and `ep_done` are unaffected; the header count and toggle are ignored.
- R6: When a frame closes partway through a byte, the partial bits are discarded and the FIFO is unchanged.
- R7: A zero-length frame is a header with count 0 followed by a single extra `sck` clock. It pushes nothing, sets `ep_count` to 0 and clears `ep_done`.
- R8: A pulse on `sck` that lasts fewer than `FILT_CYC` clock cycles is ignored and does not shift a bit.
- R9: A one-cycle `ep_sent` pulse sets `ep_done` to 1 when no FIFO frame closes in the same cycle.
- R10: `fifo_rdata` shows the oldest stored byte. A `fifo_pop` removes that byte and lowers `fifo_fill` by one. A pop on an empty FIFO has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock from the controller (asynchronous) |
| sin | input | 1 | Frame line; high while a write frame is open (asynchronous) |
| sdi | input | 1 | Serial data from the controller (asynchronous) |
| fifo_pop | input | 1 | USB side removes the oldest FIFO byte |
| fifo_rdata | output | 8 | Oldest FIFO byte |
| fifo_fill | output | $clog2(FIFO_DEPTH)+1 | Number of stored bytes |
| reg_wr | output | 1 | Register write strobe |
| reg_addr | output | 3 | Register write address (the header target) |
| reg_wdata | output | 8 | Register write data |
| ep_count | output | 4 | Byte count latched from the last FIFO frame header |
| ep_toggle | output | 1 | Toggle flag latched from the last FIFO frame header |
| ep_done | output | 1 | Endpoint transmit-done flag |
| ep_sent | input | 1 | USB side reports that a transmission finished |

## Verification
The bench sends more bytes than the FIFO holds and checks that the oldest bytes are lost and the fill level saturates. A design that wraps the count or drops the newest bytes returns the wrong sequence. It ends one frame five bits into a byte and sends a header-only frame with a single extra clock; a design that keeps a partial byte shows a raised fill level. It injects a short high glitch on `sck` inside a byte; a design with a missing or weak filter shifts in a stray bit and corrupts the stored value. Register-target frames are checked for exact write strobes and for leaving the endpoint count, toggle and done flag unchanged, which catches a design that acts on the ignored header fields.

// File: rtl/ser_load_pkg.sv
package ser_load_pkg;

    localparam int BYTE_W = 8;
    localparam int TGT_W  = 3;
    localparam int CNT_W  = 4;
    localparam logic [TGT_W-1:0] TGT_FIFO = '0;

    typedef struct packed {
        logic [TGT_W-1:0] target;
        logic             toggle;
        logic [CNT_W-1:0] count;
    } hdr_t;

    function automatic logic [BYTE_W-1:0] shift_lsb_first(
        input logic [BYTE_W-1:0] cur,
        input logic              bit_in
    );
        return {bit_in, cur[BYTE_W-1:1]};
    endfunction

endpackage

// File: rtl/ser_load_filt.sv
module ser_load_filt #(
    parameter int STAGES   = 2,
    parameter int FILT_CYC = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic clean
);
    localparam int CW = $clog2(FILT_CYC + 1);

    logic [STAGES-1:0] sync_q;
    logic [CW-1:0]     run_cnt;
    logic              synced;

    assign synced = sync_q[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= '0;
            run_cnt <= '0;
            clean   <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], raw};
            if (synced != clean) begin
                if (run_cnt == CW'(FILT_CYC - 1)) begin
                    clean   <= synced;
                    run_cnt <= '0;
                end else begin
                    run_cnt <= run_cnt + 1'b1;
                end
            end else begin
                run_cnt <= '0;
            end
        end
    end

endmodule

// File: rtl/ser_load_frame.sv
module ser_load_frame
    import ser_load_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sck_f,
    input  logic              sin_f,
    input  logic              sdi_f,
    output logic              push,
    output logic              reg_wr,
    output logic [TGT_W-1:0]  reg_addr,
    output logic [BYTE_W-1:0] byte_data,
    output logic              fin,
    output hdr_t              fin_hdr
);
    logic              sck_q, sin_q;
    logic              active, have_hdr;
    hdr_t              hdr;
    logic [BYTE_W-1:0] sreg;
    logic [2:0]        bitcnt;
    logic [BYTE_W-1:0] nxt;

    assign nxt     = shift_lsb_first(sreg, sdi_f);
    assign fin_hdr = hdr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q     <= 1'b0;
            sin_q     <= 1'b0;
            active    <= 1'b0;
            have_hdr  <= 1'b0;
            hdr       <= '0;
            sreg      <= '0;
            bitcnt    <= '0;
            push      <= 1'b0;
            reg_wr    <= 1'b0;
            reg_addr  <= '0;
            byte_data <= '0;
            fin       <= 1'b0;
        end else begin
            sck_q  <= sck_f;
            sin_q  <= sin_f;
            push   <= 1'b0;
            reg_wr <= 1'b0;
            fin    <= 1'b0;
            if (sin_f && !sin_q) begin
                active   <= 1'b1;
                have_hdr <= 1'b0;
                bitcnt   <= '0;
            end else if (active && !sin_f && sin_q) begin
                active <= 1'b0;
                if (have_hdr && hdr.target == TGT_FIFO)
                    fin <= 1'b1;
            end else if (active && sck_f && !sck_q) begin
                sreg   <= nxt;
                bitcnt <= bitcnt + 1'b1;
                if (bitcnt == 3'd7) begin
                    if (!have_hdr) begin
                        hdr      <= hdr_t'(nxt);
                        have_hdr <= 1'b1;
                    end else if (hdr.target == TGT_FIFO) begin
                        push      <= 1'b1;
                        byte_data <= nxt;
                    end else begin
                        reg_wr    <= 1'b1;
                        reg_addr  <= hdr.target;
                        byte_data <= nxt;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/ser_load_fifo.sv
module ser_load_fifo
    import ser_load_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              pop,
    output logic [BYTE_W-1:0] rdata,
    output logic [CW-1:0]     fill
);
    logic [BYTE_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wp, rp;
    logic              do_pop, full;

    assign do_pop = pop && (fill != '0);
    assign full   = (fill == CW'(DEPTH));
    assign rdata  = mem[rp];

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp   <= '0;
            rp   <= '0;
            fill <= '0;
        end else begin
            if (push) wp <= wp + 1'b1;
            if (push && !do_pop) begin
                if (full) rp   <= rp + 1'b1;
                else      fill <= fill + 1'b1;
            end else if (do_pop && !push) begin
                rp   <= rp + 1'b1;
                fill <= fill - 1'b1;
            end else if (do_pop && push) begin
                rp <= rp + 1'b1;
            end
        end
    end

endmodule

// File: rtl/ser_load_rx.sv
module ser_load_rx
    import ser_load_pkg::*;
#(
    parameter int FIFO_DEPTH  = 8,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_CYC    = 32,
    localparam int CW = $clog2(FIFO_DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sck,
    input  logic              sin,
    input  logic              sdi,
    input  logic              fifo_pop,
    output logic [BYTE_W-1:0] fifo_rdata,
    output logic [CW-1:0]     fifo_fill,
    output logic              reg_wr,
    output logic [TGT_W-1:0]  reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic [CNT_W-1:0]  ep_count,
    output logic              ep_toggle,
    output logic              ep_done,
    input  logic              ep_sent
);
    localparam int NLINES = 3;

    logic [NLINES-1:0] raw_lines, clean_lines;
    logic              byte_push, frame_fin;
    logic [BYTE_W-1:0] byte_data;
    hdr_t              fin_hdr;

    assign raw_lines = {sdi, sin, sck};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        ser_load_filt #(.STAGES(SYNC_STAGES), .FILT_CYC(FILT_CYC)) u_filt (
            .clk  (clk),
            .rst  (rst),
            .raw  (raw_lines[g]),
            .clean(clean_lines[g])
        );
    end

    ser_load_frame u_frame (
        .clk      (clk),
        .rst      (rst),
        .sck_f    (clean_lines[0]),
        .sin_f    (clean_lines[1]),
        .sdi_f    (clean_lines[2]),
        .push     (byte_push),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .byte_data(byte_data),
        .fin      (frame_fin),
        .fin_hdr  (fin_hdr)
    );

    assign reg_wdata = byte_data;

    ser_load_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk  (clk),
        .rst  (rst),
        .push (byte_push),
        .wdata(byte_data),
        .pop  (fifo_pop),
        .rdata(fifo_rdata),
        .fill (fifo_fill)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ep_done   <= 1'b1;
            ep_count  <= '0;
            ep_toggle <= 1'b0;
        end else if (frame_fin) begin
            ep_done   <= 1'b0;
            ep_count  <= fin_hdr.count;
            ep_toggle <= fin_hdr.toggle;
        end else if (ep_sent) begin
            ep_done <= 1'b1;
        end
    end

endmodule

// File: rtl/ser_load_rx_chk.sv
module ser_load_rx_chk #(
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst,
    input logic [CW-1:0] fill,
    input logic          reg_wr,
    input logic          push,
    input logic          fin,
    input logic          ep_done,
    input logic          ep_sent
);
    logic [CW-1:0] fill_q;

    always_ff @(posedge clk) begin
        if (rst) fill_q <= '0;
        else     fill_q <= fill;
    end

    a_r3_fill_bound: assert property (@(posedge clk) disable iff (rst)
        fill <= CW'(DEPTH));

    a_r10_fill_step: assert property (@(posedge clk) disable iff (rst)
        (fill != fill_q) |-> (fill == CW'(fill_q + 1'b1) || CW'(fill + 1'b1) == fill_q));

    a_r5_no_push_on_reg: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && push));

    a_r5_single_strobe: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> !reg_wr);

    a_r4_done_clear: assert property (@(posedge clk) disable iff (rst)
        $fell(ep_done) |-> $past(fin));

    a_r9_done_set: assert property (@(posedge clk) disable iff (rst)
        $rose(ep_done) |-> $past(ep_sent));

endmodule

bind ser_load_rx ser_load_rx_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .fill   (fifo_fill),
    .reg_wr (reg_wr),
    .push   (byte_push),
    .fin    (frame_fin),
    .ep_done(ep_done),
    .ep_sent(ep_sent)
);

// File: tb/ser_load_rx_tb.sv
module ser_load_rx_tb;
    localparam int DEPTH = 8;
    localparam int H     = 48;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sck = 1'b0, sin = 1'b0, sdi = 1'b0;
    logic       fifo_pop = 1'b0, ep_sent = 1'b0;
    logic [7:0] fifo_rdata, reg_wdata;
    logic [3:0] fifo_fill, ep_count;
    logic [2:0] reg_addr;
    logic       reg_wr, ep_toggle, ep_done;

    int checks = 0, failures = 0;
    bit finished = 0;
    logic [7:0]  mq[$];
    logic [10:0] rq[$];

    always #4 clk = ~clk;

    ser_load_rx u_dut (
        .clk(clk), .rst(rst), .sck(sck), .sin(sin), .sdi(sdi),
        .fifo_pop(fifo_pop), .fifo_rdata(fifo_rdata), .fifo_fill(fifo_fill),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .ep_count(ep_count), .ep_toggle(ep_toggle), .ep_done(ep_done),
        .ep_sent(ep_sent)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic send_bit(input logic b);
        sdi = b; wclk(H);
        sck = 1'b1; wclk(H);
        sck = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) send_bit(b[i]);
    endtask

    task automatic open_frame();
        sck = 1'b0; sdi = 1'b0; sin = 1'b1; wclk(H);
    endtask

    task automatic close_frame();
        sdi = 1'b0; wclk(H);
        sin = 1'b0; wclk(120);
    endtask

    // driver: sends a byte and records the expected result
    task automatic drive_byte(input logic [7:0] hdr, input logic [7:0] b);
        if (hdr[7:5] == 3'd0) begin
            if (mq.size() == DEPTH) void'(mq.pop_front());
            mq.push_back(b);
        end else begin
            rq.push_back({hdr[7:5], b});
        end
        send_byte(b);
    endtask

    // monitor: register write strobes against the scoreboard
    always @(negedge clk) begin
        if (!rst && reg_wr) begin
            if (rq.size() == 0) begin
                chk(1'b0, "R5 unexpected reg_wr", {reg_addr, reg_wdata}, 0);
            end else begin
                chk({reg_addr, reg_wdata} == rq[0], "R5 reg write",
                    {reg_addr, reg_wdata}, rq[0]);
                void'(rq.pop_front());
            end
        end
    end

    task automatic drain(input string tag);
        while (mq.size() > 0) begin
            @(negedge clk);
            chk(fifo_fill == 4'(mq.size()), {tag, " fill"}, fifo_fill, mq.size());
            chk(fifo_rdata == mq[0], {tag, " data"}, fifo_rdata, mq[0]);
            void'(mq.pop_front());
            fifo_pop = 1'b1;
            @(negedge clk);
            fifo_pop = 1'b0;
        end
        @(negedge clk);
        chk(fifo_fill == 0, {tag, " R10 empty after drain"}, fifo_fill, 0);
    endtask

    initial begin
        wclk(200000);
        chk(1'b0, "watchdog R1..", 0, 1);
        summary();
    end

    initial begin
        wclk(5);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(fifo_fill == 0, "R1 fill", fifo_fill, 0);
        chk(ep_done == 1'b1, "R1 ep_done", ep_done, 1);
        chk(ep_count == 0, "R1 ep_count", ep_count, 0);
        chk(ep_toggle == 1'b0, "R1 ep_toggle", ep_toggle, 0);
        chk(reg_wr == 1'b0, "R1 reg_wr", reg_wr, 0);

        // R2, R4: FIFO frame, target 0, toggle 1, count 3
        open_frame();
        send_byte(8'h13);
        drive_byte(8'h13, 8'hA5);
        drive_byte(8'h13, 8'h3C);
        drive_byte(8'h13, 8'hF0);
        close_frame();
        @(negedge clk);
        chk(ep_count == 4'd3, "R4 ep_count", ep_count, 3);
        chk(ep_toggle == 1'b1, "R4 ep_toggle", ep_toggle, 1);
        chk(ep_done == 1'b0, "R4 ep_done cleared", ep_done, 0);
        chk(fifo_fill == 4'd3, "R3 fill count", fifo_fill, 3);
        drain("R2 lsb-first order");

        // R9: USB side reports a finished transmission
        @(negedge clk); ep_sent = 1'b1;
        @(negedge clk); ep_sent = 1'b0;
        @(negedge clk);
        chk(ep_done == 1'b1, "R9 ep_done set", ep_done, 1);

        // R5: register target 2, count/toggle fields ignored
        open_frame();
        send_byte(8'h5F);
        drive_byte(8'h5F, 8'h11);
        drive_byte(8'h5F, 8'h22);
        close_frame();
        @(negedge clk);
        chk(rq.size() == 0, "R5 all writes seen", rq.size(), 0);
        chk(fifo_fill == 0, "R5 fifo untouched", fifo_fill, 0);
        chk(ep_count == 4'd3, "R5 ep_count kept", ep_count, 3);
        chk(ep_toggle == 1'b1, "R5 ep_toggle kept", ep_toggle, 1);
        chk(ep_done == 1'b1, "R5 ep_done kept", ep_done, 1);

        // R3: overflow, 10 bytes into an 8-deep FIFO
        open_frame();
        send_byte(8'h04);
        for (int i = 0; i < 10; i++) drive_byte(8'h04, 8'(8'h40 + i));
        close_frame();
        @(negedge clk);
        chk(fifo_fill == 4'(DEPTH), "R3 fill saturates", fifo_fill, DEPTH);
        chk(ep_count == 4'd4, "R4 ep_count overflow frame", ep_count, 4);
        chk(ep_toggle == 1'b0, "R4 ep_toggle 0", ep_toggle, 0);
        drain("R3 oldest overwritten");

        // R6: frame closes five bits into a byte
        open_frame();
        send_byte(8'h02);
        drive_byte(8'h02, 8'h81);
        drive_byte(8'h02, 8'h7E);
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        close_frame();
        @(negedge clk);
        chk(fifo_fill == 4'd2, "R6 partial byte dropped", fifo_fill, 2);
        drain("R6 stored bytes");

        // R7: zero-length frame with one extra clock
        @(negedge clk); ep_sent = 1'b1;
        @(negedge clk); ep_sent = 1'b0;
        open_frame();
        send_byte(8'h00);
        send_bit(1'b1);
        close_frame();
        @(negedge clk);
        chk(fifo_fill == 0, "R7 nothing pushed", fifo_fill, 0);
        chk(ep_count == 0, "R7 ep_count zero", ep_count, 0);
        chk(ep_done == 1'b0, "R7 ep_done cleared", ep_done, 0);

        // R8: short glitch on sck inside a byte
        open_frame();
        send_byte(8'h01);
        mq.push_back(8'hC6);
        for (int i = 0; i < 8; i++) begin
            send_bit(i[0] ? 1'b1 : 1'b0 ^ 1'b0);
            if (i == 3) begin
                sdi = 1'b1; wclk(H / 2);
                sck = 1'b1; wclk(10);
                sck = 1'b0; wclk(H / 2);
            end
        end
        close_frame();
        @(negedge clk);
        chk(fifo_fill == 4'd1, "R8 one byte after glitch", fifo_fill, 1);
        mq.delete();
        mq.push_back(8'hAA);
        drain("R8 glitch ignored");

        // R10: pop on empty FIFO
        @(negedge clk); fifo_pop = 1'b1;
        @(negedge clk); fifo_pop = 1'b0;
        @(negedge clk);
        chk(fifo_fill == 0, "R10 pop on empty", fifo_fill, 0);

        summary();
    end

endmodule